// File: doc/BRIEF.md
# Radix-4 Booth Generate-Add Row

This block is one row of a signed array multiplier. It takes the multiplicand, a three-bit overlapping window of the multiplier, and the upper part of the running sum that the row above produced. It forms one radix-4 Booth partial product and folds in sign extension without replicating sign bits. It adds the carried-in sum and the negate bit, and returns a new running sum. The two lowest bits of that sum are finished product bits and leave the array here. The remaining bits go down to the next row.

The row is purely combinational. A zero selection is built as an all-ones complement plus one, so the carry-in bit is simply the top bit of the window. Instead of keeping a separate carry out, the next row takes the previous sum with its top bit inverted. Rows can therefore be chained by wiring `sum_hi_o` of one row to `prev_hi_i` of the next. A register can sit between any two rows.

Top module: `booth_gen_add_row`

## Requirements
In the following, m = WIDTH. A is `a_i` read as signed two's complement. P is `prev_hi_i` read as unsigned, and p is its top bit `prev_hi_i[m-1]`. The row result is the (m+2)-bit value {`sum_hi_o`, `prod_bits_o`}, which equals (3·2^m + d·A + P + (1−p)·2^m) mod 2^(m+2), where d is the Booth digit selected by `booth_i` = {b2, b1, b0}.
- R1: Windows 3'b000 and 3'b111 select d = 0.
- R2: Windows 3'b001 and 3'b010 select d = +1.
- R3: Window 3'b011 selects d = +2.
- R4: Window 3'b100 selects d = −2.
- R5: Windows 3'b101 and 3'b110 select d = −1.
- R6: The result is correct for the extreme multiplicands −2^(m−1) and 2^(m−1)−1 under every window.
- R7: `prod_bits_o` equals bits [1:0] of (d·A + P).
- R8: Any carry above bit m+1 is discarded. `sum_hi_o` holds result bits [m+1:2], and `prod_bits_o` holds bits [1:0].
- R9: For equal `a_i` and `prev_hi_i`, windows 3'b000 and 3'b111 give identical outputs.
- R10: With all inputs zero, both outputs are zero, because the leading one and the inverted top bit wrap out of the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | Multiplicand, signed two's complement |
| booth_i | input | 3 | Booth window {b(2i+1), b(2i), b(2i−1)} |
| prev_hi_i | input | WIDTH | Bits [m+1:2] of the previous row's result |
| prod_bits_o | output | 2 | Two finished product bits of this row |
| sum_hi_o | output | WIDTH | Bits [m+1:2] of this row's result, passed to the next row |

## Verification
The checker's immediate assertions assume that every input carries a known two-state value and that the inputs have settled before the row is evaluated. The checker computes its reference from the window digit directly, so it relies on WIDTH being at least 2. The stimulus drives all three inputs together from one task and leaves none of them undriven. It samples the outputs half a clock later, so the assertions and the bench both see settled values.

// File: rtl/booth_row_pkg.sv
package booth_row_pkg;
  typedef struct packed {
    logic one;  // select +-A
    logic two;  // select +-2A
    logic neg;  // complement and carry-in
  } booth_sel_t;
endpackage

// File: rtl/booth_win_dec.sv
module booth_win_dec
  import booth_row_pkg::*;
(
  input  logic [2:0]  win_i,
  output booth_sel_t  sel_o
);
  always_comb begin
    sel_o.one = win_i[0] ^ win_i[1];
    sel_o.two = (win_i[2] & ~win_i[1] & ~win_i[0]) |
                (~win_i[2] & win_i[1] & win_i[0]);
    // 111 selects nothing, then complement + 1 yields zero
    sel_o.neg = win_i[2];
  end
endmodule

// File: rtl/booth_pp_gen.sv
module booth_pp_gen
  import booth_row_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int PPW  = WIDTH + 1
) (
  input  logic [WIDTH-1:0] a_i,
  input  booth_sel_t       sel_i,
  output logic [PPW-1:0]   pp_o
);
  logic [PPW-1:0] a_ext;
  assign a_ext = {a_i[WIDTH-1], a_i};

  for (genvar j = 0; j < PPW; j++) begin : g_bit
    if (j == 0) begin : g_lsb
      assign pp_o[j] = (sel_i.one & a_ext[j]) ^ sel_i.neg;
    end else begin : g_rest
      assign pp_o[j] = ((sel_i.one & a_ext[j]) | (sel_i.two & a_ext[j-1])) ^ sel_i.neg;
    end
  end
endmodule

// File: rtl/booth_row_add.sv
module booth_row_add #(
  parameter int WIDTH = 8,
  localparam int PPW  = WIDTH + 1,
  localparam int SW   = WIDTH + 2
) (
  input  logic [PPW-1:0]   pp_i,
  input  logic             neg_i,
  input  logic [WIDTH-1:0] prev_hi_i,
  output logic [SW-1:0]    sum_o
);
  logic [SW-1:0] x_op, y_op;

  // leading one, inverted sign: sign extension without replication
  assign x_op  = {1'b1, ~pp_i[PPW-1], pp_i[PPW-2:0]};
  // inverted top bit stands in for the dropped carry of the row above
  assign y_op  = {1'b0, ~prev_hi_i[WIDTH-1], prev_hi_i};
  assign sum_o = x_op + y_op + SW'(neg_i);
endmodule

// File: rtl/booth_gen_add_row.sv
module booth_gen_add_row
  import booth_row_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [2:0]       booth_i,
  input  logic [WIDTH-1:0] prev_hi_i,
  output logic [1:0]       prod_bits_o,
  output logic [WIDTH-1:0] sum_hi_o
);
  localparam int PPW = WIDTH + 1;
  localparam int SW  = WIDTH + 2;

  booth_sel_t     sel;
  logic [PPW-1:0] pp;
  logic [SW-1:0]  row_sum;

  booth_win_dec u_dec (
    .win_i (booth_i),
    .sel_o (sel)
  );

  booth_pp_gen #(.WIDTH(WIDTH)) u_pp (
    .a_i   (a_i),
    .sel_i (sel),
    .pp_o  (pp)
  );

  booth_row_add #(.WIDTH(WIDTH)) u_add (
    .pp_i      (pp),
    .neg_i     (sel.neg),
    .prev_hi_i (prev_hi_i),
    .sum_o     (row_sum)
  );

  assign prod_bits_o = row_sum[1:0];
  assign sum_hi_o    = row_sum[SW-1:2];
endmodule

// File: rtl/booth_row_chk.sv
module booth_row_chk #(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0] a_i,
  input logic [2:0]       booth_i,
  input logic [WIDTH-1:0] prev_hi_i,
  input logic [1:0]       prod_bits_o,
  input logic [WIDTH-1:0] sum_hi_o
);
  localparam int XW = WIDTH + 4;

  logic [XW-1:0] a_w, prev_w, d_a, ref_tot, ref_low;
  logic [WIDTH+1:0] got;

  always_comb begin
    a_w    = {{4{a_i[WIDTH-1]}}, a_i};
    prev_w = {4'b0, prev_hi_i};
    case (booth_i)
      3'b001, 3'b010: d_a = a_w;
      3'b011:         d_a = a_w << 1;
      3'b100:         d_a = -(a_w << 1);
      3'b101, 3'b110: d_a = -a_w;
      default:        d_a = '0;
    endcase
    ref_tot = (XW'(3) << WIDTH) + d_a + prev_w +
              (prev_hi_i[WIDTH-1] ? '0 : (XW'(1) << WIDTH));
    ref_low = d_a + prev_w;
    got     = {sum_hi_o, prod_bits_o};
  end

  always_comb begin
    if (booth_i == 3'b000 || booth_i == 3'b111)
      AST_ZERO_SEL: assert (got == ref_tot[WIDTH+1:0]) else $error("zero select"); // R1
    if (booth_i == 3'b001 || booth_i == 3'b010)
      AST_PLUS_ONE: assert (got == ref_tot[WIDTH+1:0]) else $error("+A select"); // R2
    if (booth_i == 3'b011)
      AST_PLUS_TWO: assert (got == ref_tot[WIDTH+1:0]) else $error("+2A select"); // R3
    if (booth_i == 3'b100)
      AST_MINUS_TWO: assert (got == ref_tot[WIDTH+1:0]) else $error("-2A select"); // R4
    if (booth_i == 3'b101 || booth_i == 3'b110)
      AST_MINUS_ONE: assert (got == ref_tot[WIDTH+1:0]) else $error("-A select"); // R5
    AST_PROD_PAIR: assert (prod_bits_o == ref_low[1:0]) else $error("product bits"); // R7
    AST_HI_FIELD: assert (sum_hi_o == ref_tot[WIDTH+1:2]) else $error("upper field"); // R8
    if (a_i == '0 && booth_i == 3'b000 && prev_hi_i == '0)
      AST_QUIET_ZERO: assert (got == '0) else $error("all-zero inputs"); // R10
  end
endmodule

bind booth_gen_add_row booth_row_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i         (a_i),
  .booth_i     (booth_i),
  .prev_hi_i   (prev_hi_i),
  .prod_bits_o (prod_bits_o),
  .sum_hi_o    (sum_hi_o)
);

// File: tb/booth_gen_add_row_tb.sv
module booth_gen_add_row_tb;
  localparam int W  = 8;
  localparam int VW = 2 * W + 3;
  localparam int NV = 12;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [W-1:0] a_i, prev_hi_i, sum_hi_o;
  logic [2:0]   booth_i;
  logic [1:0]   prod_bits_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  booth_gen_add_row #(.WIDTH(W)) u_dut (
    .a_i         (a_i),
    .booth_i     (booth_i),
    .prev_hi_i   (prev_hi_i),
    .prod_bits_o (prod_bits_o),
    .sum_hi_o    (sum_hi_o)
  );

  // {a, window, prev}
  localparam logic [VW-1:0] VEC [NV] = '{
    {8'h00, 3'b000, 8'h00}, {8'h35, 3'b000, 8'hA7},
    {8'h35, 3'b111, 8'h12}, {8'h4B, 3'b001, 8'h3C},
    {8'hC9, 3'b010, 8'hF0}, {8'h27, 3'b011, 8'h81},
    {8'h9D, 3'b011, 8'h05}, {8'h27, 3'b100, 8'h66},
    {8'hE2, 3'b100, 8'hFF}, {8'h5A, 3'b101, 8'h40},
    {8'hB3, 3'b110, 8'hC8}, {8'h7F, 3'b011, 8'hFF}
  };

  function automatic int digit(input logic [2:0] w);
    case (w)
      3'b001, 3'b010: return 1;
      3'b011:         return 2;
      3'b100:         return -2;
      3'b101, 3'b110: return -1;
      default:        return 0;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] w);
    case (w)
      3'b001, 3'b010: return "R2";
      3'b011:         return "R3";
      3'b100:         return "R4";
      3'b101, 3'b110: return "R5";
      default:        return "R1";
    endcase
  endfunction

  function automatic int exp_full(input logic [W-1:0] a, input logic [2:0] w,
                                  input logic [W-1:0] p);
    int sa, t;
    sa = int'($signed(a));
    t  = (3 << W) + digit(w) * sa + int'(p) + (p[W-1] ? 0 : (1 << W));
    return t & ((1 << (W + 2)) - 1);
  endfunction

  task automatic apply(input logic [W-1:0] a, input logic [2:0] w, input logic [W-1:0] p);
    @(posedge clk);
    a_i = a; booth_i = w; prev_hi_i = p;
    @(negedge clk);
  endtask

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=0x%0h exp=0x%0h (a=%0h w=%b p=%0h)", tag, got, exp,
               a_i, booth_i, prev_hi_i);
    end
  endtask

  task automatic run(input string tag, input logic [W-1:0] a, input logic [2:0] w,
                     input logic [W-1:0] p);
    int low;
    apply(a, w, p);
    check(tag, int'({sum_hi_o, prod_bits_o}), exp_full(a, w, p));
    low = (digit(w) * int'($signed(a)) + int'(p)) & 3;
    check("R7", int'(prod_bits_o), low);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] lf;
    a_i = '0; booth_i = '0; prev_hi_i = '0;
    @(negedge clk);
    // R10: quiescent inputs give zero outputs
    check("R10", int'({sum_hi_o, prod_bits_o}), 0);

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      run(tag_of(v[W+2:W]), v[VW-1:W+3], v[W+2:W], v[W-1:0]);
    end

    // R6: extreme multiplicands under every window
    for (int w = 0; w < 8; w++) begin
      run("R6", 8'h80, 3'(w), 8'h00);
      run("R6", 8'h7F, 3'(w), 8'hFF);
      run("R6", 8'h80, 3'(w), 8'h7F);
    end

    // R8: overflowing sums drop the carry, fields split at bit 2
    apply(8'h7F, 3'b011, 8'hFF);
    check("R8", int'(sum_hi_o), exp_full(8'h7F, 3'b011, 8'hFF) >> 2);
    check("R8", int'(prod_bits_o), exp_full(8'h7F, 3'b011, 8'hFF) & 3);
    apply(8'h80, 3'b100, 8'hFE);
    check("R8", int'(sum_hi_o), exp_full(8'h80, 3'b100, 8'hFE) >> 2);

    // R9: both zero windows agree
    lf = 8'h5D;
    for (int k = 0; k < 16; k++) begin
      int r0;
      logic [W-1:0] pv;
      pv = lf ^ 8'hA3;
      apply(lf, 3'b000, pv);
      r0 = int'({sum_hi_o, prod_bits_o});
      apply(lf, 3'b111, pv);
      check("R9", int'({sum_hi_o, prod_bits_o}), r0);
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    end

    // sweep with pseudo-random operands across all windows
    for (int k = 0; k < 200; k++) begin
      logic [W-1:0] pv;
      pv = {lf[3:0], lf[7:4]} ^ 8'(k);
      run(tag_of(3'(k)), lf, 3'(k), pv);
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule